// File: doc/BRIEF.md
# Serial DAC Host Sequencer

This block is the master side of a link to a 16-bit serial digital-to-analog converter. Commands arrive on a valid/ready handshake, and the block turns each one into the pin waveform the converter expects on its chip-select, serial clock, data and load-strobe lines. The serial clock comes from the system clock through a symmetric divider, so it always has a 50% duty cycle. All setup, hold, gap and pulse widths are counted in system clock cycles.

Five operations are supported:

- **Write-and-update**: a word is shifted in while the load strobe is low, so the output changes as soon as chip-select rises.
- **Write-and-hold**: a word is shifted in while the load strobe is high, so the output is held.
- **Load**: a pulse on the load strobe, issued only while chip-select is high. Several converters that share the strobe then update together.
- **Sleep**: the power-down pattern, which is one serial-clock transition followed by two chip-select pulses. The clock is then parked.
- **Wake**: one chip-select pulse followed by a programmable settling wait. The default wait is 50 µs of system clock.

While the converter is asleep or settling, write commands are not dropped. They wait behind a low ready. A write that arrives during sleep starts the wake sequence by itself.

Top module: `sdac_host`

## Requirements
- R1: While reset is applied, cs_n is 1, sclk is 0, din is 0 and ldac_n equals the LDAC_RST parameter (default 0). cmd_ready stays 0 until the second rising clock after reset is released, and is 1 from then on.
- R2: A write (op 0 or 1) sends 16 bits, most significant bit first, in this order:
  - cs_n falls first, and SETUP_CYC cycles with sclk low follow.
  - Each bit then has HALF_CYC cycles with sclk low and then HALF_CYC cycles with sclk high.
  - din changes only at the clock edge where sclk falls, so it is stable at every rising sclk.
- R3: cs_n stays 0 from the first bit to the last. It rises HOLD_CYC cycles after the last sclk fall and then stays high for GAP_CYC cycles. cmd_ready is 0 whenever cs_n is 0 and throughout that gap.
- R4: Op 0 (write-and-update) leaves ldac_n at 0 once the command is finished. If ldac_n was 0, it stays 0 through the frame. If ldac_n was 1, it stays 1 through the frame and falls one cycle after the gap ends.
- R5: Op 1 (write-and-hold) raises ldac_n at the edge where cs_n falls, and ldac_n remains 1 after the command.
- R6: Op 2 (load) keeps cs_n at 1 and sclk at 0. It drives ldac_n to 0 for LOAD_CYC cycles, then to 1 for LOAD_CYC cycles, then back to the level left by the last write.
- R7: ldac_n only falls when cs_n was 1 both in the cycle before the fall and in the cycle of the fall.
- R8: Op 3 (sleep), given while awake, runs this sequence with each step lasting GAP_CYC cycles:
  - sclk rises while cs_n is 1;
  - cs_n goes 0;
  - cs_n goes 1;
  - cs_n goes 0.
  After that, cs_n is 1 and sclk is held at 1 until the converter is woken.
- R9: Op 4 (wake) drives cs_n to 0 for GAP_CYC cycles and then holds cs_n at 1 for WAKE_US*CLK_MHZ cycles with cmd_ready at 0. sclk keeps its parked level through both phases and returns to 0 after them.
- R10: While asleep, cmd_ready is 1 only when cmd_op is 3 or 4. Any other valid command starts the wake sequence without being consumed, and it is accepted and performed once the wait ends.
- R11: Op 3 given while asleep is accepted and changes no pin.
- R12: Ops 5 to 7 are accepted while awake and change no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on a clock where both valid and ready are high |
| cmd_op | input | 3 | 0 write-and-update, 1 write-and-hold, 2 load, 3 sleep, 4 wake, 5–7 ignored |
| cmd_data | input | WORD_W | Word for ops 0 and 1 |
| dac_cs_n | output | 1 | Chip-select, active low |
| dac_sclk | output | 1 | Serial clock |
| dac_din | output | 1 | Serial data |
| dac_ldac_n | output | 1 | Load strobe, active low |

## Verification
Four properties are checked on every cycle:
- the load strobe never falls unless chip-select was high in that cycle and the one before;
- ready stays low while chip-select is low;
- inside a frame, data moves only when the serial clock falls;
- every chip-select window has either exactly sixteen rising clocks or none, and the load strobe holds still inside that window.

Only the bench's scenarios can show the rest:
- the exact phase lengths, and the word recovered from the data line;
- the strobe level that follows each write mode;
- the auto-wake of a pending write during sleep;
- that repeated sleep and unused op codes leave the pins untouched.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  typedef enum logic [2:0] {
    OP_WR_NOW  = 3'd0,
    OP_WR_HOLD = 3'd1,
    OP_LOAD    = 3'd2,
    OP_SLEEP   = 3'd3,
    OP_WAKE    = 3'd4
  } sdac_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_CSHOLD, ST_GAP,
    ST_LDLOW, ST_LDREC,
    ST_SLTOG, ST_SLP1, ST_SLGAP, ST_SLP2, ST_SLEEP,
    ST_WKP, ST_WKW
  } sdac_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_phase_timer.sv
module sdac_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              shift_en,
  output logic              msb
);
  logic [WORD_W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)          sr_d = load_data;
    else if (shift_en) sr_d = {sr_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign msb = sr_q[WORD_W-1];
endmodule

// File: rtl/sdac_host.sv
module sdac_host
  import sdac_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CLK_MHZ   = 125,
  parameter int HALF_CYC  = 7,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int GAP_CYC   = 4,
  parameter int LOAD_CYC  = 4,
  parameter int WAKE_US   = 50,
  parameter bit LDAC_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              dac_cs_n,
  output logic              dac_sclk,
  output logic              dac_din,
  output logic              dac_ldac_n
);
  localparam int WAKE_CYC = WAKE_US * CLK_MHZ;
  localparam int MAXLEN   = max2(max2(max2(HALF_CYC, SETUP_CYC), max2(HOLD_CYC, GAP_CYC)),
                                 max2(LOAD_CYC, WAKE_CYC));
  localparam int CNT_W    = $clog2(MAXLEN + 1);
  localparam int BIT_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] T_HALF  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] T_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] T_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] T_GAP   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] T_LOAD  = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] T_WAKE  = CNT_W'(WAKE_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  // reset: asserted at once, released after two clocks
  logic [1:0] rsync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  logic core_rst_n;
  assign core_rst_n = rsync_q[1];

  sdac_st_e         st_q, st_d;
  logic             ph_q, ph_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             lvl_q, lvl_d;
  logic             frl_q, frl_d;
  logic             wkhi_q, wkhi_d;
  logic             tmr_load, tmr_done, sh_load, sh_shift, sh_msb;
  logic [CNT_W-1:0] tmr_val;

  sdac_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(core_rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
  );

  sdac_shift #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst_n(core_rst_n), .load(sh_load), .load_data(cmd_data),
    .shift_en(sh_shift), .msb(sh_msb)
  );

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; lvl_d = lvl_q; frl_d = frl_q; wkhi_d = wkhi_q;
    tmr_load = 1'b0; tmr_val = '0; sh_load = 1'b0; sh_shift = 1'b0;
    case (st_q)
      ST_IDLE: if (cmd_valid) begin
        case (cmd_op)
          OP_WR_NOW, OP_WR_HOLD: begin
            frl_d = lvl_q | (cmd_op == OP_WR_HOLD);
            lvl_d = (cmd_op == OP_WR_HOLD);
            sh_load = 1'b1; bit_d = '0; ph_d = 1'b0;
            st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = T_SETUP;
          end
          OP_LOAD:  begin st_d = ST_LDLOW; tmr_load = 1'b1; tmr_val = T_LOAD; end
          OP_SLEEP: begin st_d = ST_SLTOG; tmr_load = 1'b1; tmr_val = T_GAP;  end
          OP_WAKE:  begin st_d = ST_WKP; wkhi_d = 1'b0; tmr_load = 1'b1; tmr_val = T_GAP; end
          default: ;
        endcase
      end
      ST_SETUP: if (tmr_done) begin st_d = ST_SHIFT; tmr_load = 1'b1; tmr_val = T_HALF; end
      ST_SHIFT: if (tmr_done) begin
        tmr_load = 1'b1;
        if (!ph_q) begin
          ph_d = 1'b1; tmr_val = T_HALF;
        end else begin
          ph_d = 1'b0;
          if (bit_q == LAST_BIT) begin
            st_d = ST_CSHOLD; tmr_val = T_HOLD;
          end else begin
            bit_d = bit_q + 1'b1; sh_shift = 1'b1; tmr_val = T_HALF;
          end
        end
      end
      ST_CSHOLD: if (tmr_done) begin st_d = ST_GAP; tmr_load = 1'b1; tmr_val = T_GAP; end
      ST_GAP:    if (tmr_done) st_d = ST_IDLE;
      ST_LDLOW:  if (tmr_done) begin st_d = ST_LDREC; tmr_load = 1'b1; tmr_val = T_LOAD; end
      ST_LDREC:  if (tmr_done) st_d = ST_IDLE;
      ST_SLTOG:  if (tmr_done) begin st_d = ST_SLP1;  tmr_load = 1'b1; tmr_val = T_GAP; end
      ST_SLP1:   if (tmr_done) begin st_d = ST_SLGAP; tmr_load = 1'b1; tmr_val = T_GAP; end
      ST_SLGAP:  if (tmr_done) begin st_d = ST_SLP2;  tmr_load = 1'b1; tmr_val = T_GAP; end
      ST_SLP2:   if (tmr_done) st_d = ST_SLEEP;
      ST_SLEEP:  if (cmd_valid && (cmd_op != OP_SLEEP)) begin
        st_d = ST_WKP; wkhi_d = 1'b1; tmr_load = 1'b1; tmr_val = T_GAP;
      end
      ST_WKP:    if (tmr_done) begin st_d = ST_WKW; tmr_load = 1'b1; tmr_val = T_WAKE; end
      ST_WKW:    if (tmr_done) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st_q <= ST_IDLE; ph_q <= 1'b0; bit_q <= '0;
      lvl_q <= LDAC_RST; frl_q <= LDAC_RST; wkhi_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d;
      lvl_q <= lvl_d; frl_q <= frl_d; wkhi_q <= wkhi_d;
    end
  end

  always_comb begin
    dac_cs_n = 1'b1; dac_sclk = 1'b0; dac_din = 1'b0; dac_ldac_n = lvl_q; cmd_ready = 1'b0;
    case (st_q)
      ST_IDLE:   cmd_ready = core_rst_n;
      ST_SETUP:  begin dac_cs_n = 1'b0; dac_din = sh_msb; dac_ldac_n = frl_q; end
      ST_SHIFT:  begin dac_cs_n = 1'b0; dac_sclk = ph_q; dac_din = sh_msb; dac_ldac_n = frl_q; end
      ST_CSHOLD: begin dac_cs_n = 1'b0; dac_ldac_n = frl_q; end
      ST_GAP:    dac_ldac_n = frl_q;
      ST_LDLOW:  dac_ldac_n = 1'b0;
      ST_LDREC:  dac_ldac_n = 1'b1;
      ST_SLTOG, ST_SLGAP: dac_sclk = 1'b1;
      ST_SLP1, ST_SLP2:   begin dac_cs_n = 1'b0; dac_sclk = 1'b1; end
      ST_SLEEP:  begin dac_sclk = 1'b1; cmd_ready = (cmd_op == OP_SLEEP) || (cmd_op == OP_WAKE); end
      ST_WKP:    begin dac_cs_n = 1'b0; dac_sclk = wkhi_q; end
      ST_WKW:    dac_sclk = wkhi_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/sdac_host_chk.sv
module sdac_host_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_ready,
  input logic dac_cs_n,
  input logic dac_sclk,
  input logic dac_din,
  input logic dac_ldac_n
);
  localparam int RW = $clog2(WORD_W + 1) + 1;
  logic [RW-1:0] rises_q;
  logic          sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q <= '0; sclk_d <= 1'b0;
    end else begin
      sclk_d <= dac_sclk;
      if (dac_cs_n)                   rises_q <= '0;
      else if (dac_sclk && !sclk_d)   rises_q <= rises_q + 1'b1;
    end
  end

  a_r7_ldac_fall_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ldac_n) |-> (dac_cs_n && $past(dac_cs_n)));

  a_r3_cs_low_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> !cmd_ready);

  a_r2_din_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !$past(dac_cs_n) && !$stable(dac_din)) |-> $fell(dac_sclk));

  a_r2_word_rises: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> ((rises_q == RW'(WORD_W)) || (rises_q == '0)));

  a_r5_ldac_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !$past(dac_cs_n)) |-> $stable(dac_ldac_n));
endmodule

bind sdac_host sdac_host_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .dac_cs_n(dac_cs_n),
  .dac_sclk(dac_sclk), .dac_din(dac_din), .dac_ldac_n(dac_ldac_n)
);

// File: tb/sdac_host_test.sv
module sdac_host_test;
  localparam int WORD_W = 16;
  localparam int HALF = 7, SETUP = 2, HOLD = 2, GAP = 4, LOADC = 4;
  localparam int WAKEC = 50 * 125;
  localparam bit LRST = 1'b0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cmd_valid, cmd_ready;
  logic [2:0] cmd_op;
  logic [WORD_W-1:0] cmd_data;
  logic dac_cs_n, dac_sclk, dac_din, dac_ldac_n;

  sdac_host #(.WORD_W(WORD_W), .CLK_MHZ(125), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
              .HOLD_CYC(HOLD), .GAP_CYC(GAP), .LOAD_CYC(LOADC), .WAKE_US(50), .LDAC_RST(LRST)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_din(dac_din),
    .dac_ldac_n(dac_ldac_n));

  int checks = 0, fails = 0;
  bit done = 0, chk_on = 0;

  typedef struct { bit cs; bit sc; bit di; bit ld; bit idle; string tag; } vec_t;
  vec_t q[$];
  vec_t cur;
  logic [WORD_W-1:0] words[$];
  bit lvl = LRST, asleep = 0;

  function automatic vec_t mk(bit cs, bit sc, bit di, bit ld, string tag);
    vec_t v; v.cs = cs; v.sc = sc; v.di = di; v.ld = ld; v.idle = 0; v.tag = tag; return v;
  endfunction

  function automatic vec_t idle_vec();
    vec_t v = mk(1'b1, asleep, 1'b0, lvl, asleep ? "R8" : "R1"); v.idle = 1; return v;
  endfunction

  task automatic push_n(int n, vec_t v);
    repeat (n) q.push_back(v);
  endtask

  task automatic model_write(bit hold, logic [WORD_W-1:0] d);
    bit fl = lvl | hold;
    string mt = hold ? "R5" : "R4";
    lvl = hold;
    words.push_back(d);
    push_n(SETUP, mk(0, 0, d[WORD_W-1], fl, mt));
    for (int i = WORD_W - 1; i >= 0; i--) begin
      push_n(HALF, mk(0, 0, d[i], fl, "R2"));
      push_n(HALF, mk(0, 1, d[i], fl, "R2"));
    end
    push_n(HOLD, mk(0, 0, 0, fl, "R3"));
    push_n(GAP,  mk(1, 0, 0, fl, "R3"));
  endtask

  task automatic model_wake();
    bit h = asleep;
    push_n(GAP,   mk(0, h, 0, lvl, "R9"));
    push_n(WAKEC, mk(1, h, 0, lvl, "R9"));
    asleep = 0;
  endtask

  // reference model: one step per rising edge
  initial cur = idle_vec();
  always @(posedge clk) begin
    if (rst_n) begin
      if (cur.idle && cmd_valid) begin
        if (asleep) begin
          if (cmd_op != 3'd3) model_wake();             // R10 / R11
        end else begin
          case (cmd_op)
            3'd0: model_write(1'b0, cmd_data);
            3'd1: model_write(1'b1, cmd_data);
            3'd2: begin
              push_n(LOADC, mk(1, 0, 0, 0, "R6"));
              push_n(LOADC, mk(1, 0, 0, 1, "R6"));
            end
            3'd3: begin
              push_n(GAP, mk(1, 1, 0, lvl, "R8"));
              push_n(GAP, mk(0, 1, 0, lvl, "R8"));
              push_n(GAP, mk(1, 1, 0, lvl, "R8"));
              push_n(GAP, mk(0, 1, 0, lvl, "R8"));
              asleep = 1;
            end
            3'd4: model_wake();
            default: ;                                  // R12
          endcase
        end
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_vec();
    end
  end

  // per-cycle comparison and word recovery
  bit prev_cs = 1, prev_sc = 0;
  int nb = 0;
  logic [WORD_W-1:0] got = '0;
  always @(negedge clk) begin
    #1;
    if (chk_on && !done) begin
      bit er;
      logic [WORD_W-1:0] ew;
      er = cur.idle ? (asleep ? (cmd_op == 3'd3 || cmd_op == 3'd4) : 1'b1) : 1'b0;
      checks++;
      if ({dac_cs_n, dac_sclk, dac_din, dac_ldac_n, cmd_ready} !== {cur.cs, cur.sc, cur.di, cur.ld, er}) begin
        fails++;
        $display("FAIL %s pins cs,sclk,din,ldac,ready actual %b%b%b%b%b expected %b%b%b%b%b at %0t",
                 cur.tag, dac_cs_n, dac_sclk, dac_din, dac_ldac_n, cmd_ready,
                 cur.cs, cur.sc, cur.di, cur.ld, er, $time);
      end
      if (!dac_cs_n && dac_sclk && !prev_sc) begin
        got = {got[WORD_W-2:0], dac_din}; nb++;
      end
      if (dac_cs_n && !prev_cs && nb != 0) begin
        ew = (words.size() != 0) ? words.pop_front() : 'x;
        checks++;
        if (nb != WORD_W || got !== ew) begin
          fails++;
          $display("FAIL R2 recovered word actual %h (%0d bits) expected %h", got, nb, ew);
        end
      end
      if (dac_cs_n) begin nb = 0; got = '0; end
    end
    prev_cs = dac_cs_n; prev_sc = dac_sclk;
  end

  task automatic chk1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic send(logic [2:0] op, logic [WORD_W-1:0] d);
    bit r;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    forever begin
      #1 r = cmd_ready;
      @(negedge clk);
      if (r) break;
    end
    cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk1("R1 cs_n in reset", dac_cs_n, 1'b1);
    chk1("R1 sclk in reset", dac_sclk, 1'b0);
    chk1("R1 din in reset", dac_din, 1'b0);
    chk1("R1 ldac_n in reset", dac_ldac_n, LRST);
    chk1("R1 ready in reset", cmd_ready, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1 chk1("R1 ready one edge after release", cmd_ready, 1'b0);
    @(negedge clk); #1 chk1("R1 ready two edges after release", cmd_ready, 1'b1);
    chk_on = 1;

    send(3'd0, 16'hA5C3);   // R4: update mode from low strobe
    send(3'd1, 16'h8001);   // R5: hold mode raises strobe with cs
    send(3'd2, '0);         // R6 / R7: load pulse
    send(3'd0, 16'h7FFE);   // R4 / R7: strobe falls only after gap
    send(3'd6, 16'hFFFF);   // R12: unused code
    send(3'd1, 16'hFFFF);   // R5
    send(3'd0, 16'h0000);   // R4
    send(3'd3, '0);         // R8: enter sleep
    send(3'd3, '0);         // R11: sleep while asleep
    repeat (10) @(negedge clk);
    send(3'd0, 16'h1234);   // R10: write while asleep wakes first
    send(3'd3, '0);         // R8
    send(3'd4, '0);         // R9: explicit wake
    send(3'd2, '0);         // R6
    send(3'd4, '0);         // R9: wake while awake

    while (q.size() != 0 || !cur.idle) @(negedge clk);
    repeat (20) @(negedge clk);
    chk1("R2 all written words seen", words.size() == 0, 1'b1);
    finish_run();
  end
endmodule